// File: doc/BRIEF.md
# Trap and Privilege State Unit

This block owns the processor's privilege bit together with the program counter and the active stack pointer, and it performs every atomic control transfer between user code and the kernel. In an ordinary cycle it accepts the sequential next PC and the updated SP from the core. When a system call, an enabled external interrupt, a fault, an abort or an illegal privileged operation is signalled, it enters kernel mode in one clock edge. In that same edge it saves the return PC, the user SP and the previous privilege level, records a cause code, moves to the kernel stack and sends the PC to the proper handler. A return strobe issued in kernel mode restores the saved privilege, SP and PC in one edge.

Entries that follow a completed instruction (system call, interrupt) save the sequential PC and SP. Entries that stop an instruction (fault, abort, privilege violation) save the current PC and SP so that the instruction can be retried. Only one level of saved context exists. A trap taken while already in kernel mode keeps the current kernel stack.

Top module: `trap_priv_unit`

## Requirements
- R1: After a synchronous active-low reset, privilege is 1 (kernel; 0 means user), PC is 0x0000_0000, SP is the kernel stack top 0x0000_F000, the interrupt enable is 0 and the cause is 0.
- R2: In a cycle with no taken event, the next PC is step_pc_i, the next SP is sp_i, and privilege is unchanged.
- R3: A system call entry sets privilege to 1 and PC to 0x0000_0100, writes cause 0, and saves step_pc_i, sp_i and the old privilege. When entered from user mode, SP becomes the kernel stack top.
- R4: An external interrupt is taken only while the enable bit is 1. It goes to 0x0000_0200 with cause 1 and saves step_pc_i and sp_i. With the enable at 0 the interrupt strobe has no effect.
- R5: A fault (cause 2) or an abort (cause 3) enters at 0x0000_0200 and saves the current PC and SP outputs rather than the sequential values.
- R6: In user mode, a privileged operation (priv_op_i, ie_wr_i or ret_i) is not performed. Instead it enters at 0x0000_0200 with cause 4 and saves the current PC and SP. The enable bit is left unchanged.
- R7: When events coincide, the priority is abort, then fault, then enabled interrupt, then privilege violation, then system call. The losing events are dropped, so an interrupt beats a system call in the same cycle.
- R8: A return in kernel mode (with no higher event) loads PC, SP and privilege from the saved context.
- R9: A trap taken in kernel mode does not switch stacks: the new SP is the value that would have been saved.
- R10: The enable bit changes only through ie_wr_i in kernel mode, in a cycle where no entry or return is taken. Trap entry and return leave it as it is.
- R11: priv_grant_o is 1 exactly when priv_op_i is asserted in kernel mode and no entry or return is taken that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_pc_i | input | 32 | Sequential next PC from the core |
| sp_i | input | 32 | SP after the current instruction |
| syscall_i | input | 1 | System call strobe |
| irq_i | input | 1 | External interrupt request |
| fault_i | input | 1 | Recoverable fault strobe |
| abort_i | input | 1 | Unrecoverable abort strobe |
| priv_op_i | input | 1 | Generic privileged operation attempt |
| ie_wr_i | input | 1 | Write strobe for the interrupt enable (privileged) |
| ie_val_i | input | 1 | Value to write to the interrupt enable |
| ret_i | input | 1 | Return-from-trap strobe (privileged) |
| pc_o | output | 32 | Current PC |
| sp_o | output | 32 | Active SP |
| priv_o | output | 1 | Privilege bit, 1 = kernel |
| ie_o | output | 1 | Interrupt enable bit |
| cause_o | output | 3 | Last recorded cause code |
| priv_grant_o | output | 1 | Privileged operation permitted this cycle |

## Verification
The bench targets coinciding strobes, above all an interrupt against a system call and an abort against a fault. A design with the wrong priority would land on the wrong handler or record the wrong cause. It also checks the saved return address for each class of entry. A design that saves the sequential PC after a fault would skip the faulting instruction on return. User-mode attempts to write the enable bit or to return are examined at the ports. A leaky design would silently enable interrupts or drop to a saved context. A nested trap taken in kernel mode must keep the current stack, and a design that always reloads the stack top would corrupt the kernel stack.

// File: rtl/trap_pkg.sv
// Shared types for the trap and privilege state unit.
// Assumes cause codes fit three bits and are read by handler software.
package trap_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_SYSCALL = 3'd0,
        CAUSE_IRQ     = 3'd1,
        CAUSE_FAULT   = 3'd2,
        CAUSE_ABORT   = 3'd3,
        CAUSE_PRIV    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACT_STEP   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } act_e;

    typedef struct packed {
        act_e   act;      // what the state registers do this edge
        cause_e cause;    // cause recorded on entry
        logic   use_cur;  // entry saves current PC/SP (instruction not done)
        logic   ie_we;    // kernel write of interrupt enable
    } decision_t;

endpackage

// File: rtl/trap_arbiter.sv
// Chooses the single action for this cycle from all event strobes.
// Purely combinational. Assumes strobes are valid for one cycle each.
// Priority: abort, fault, enabled irq, privilege violation, syscall,
// then kernel return, then the normal sequential step.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic      priv_q,
    input  logic      ie_q,
    input  logic      syscall_i,
    input  logic      irq_i,
    input  logic      fault_i,
    input  logic      abort_i,
    input  logic      priv_op_i,
    input  logic      ie_wr_i,
    input  logic      ret_i,
    output decision_t dec_o,
    output logic      grant_o
);

    localparam int NREQ = 5;

    logic [NREQ-1:0] req;      // index 0 is the highest priority
    logic            violation;

    // Form the ordered request vector for entry events.
    always_comb begin
        violation = !priv_q && (priv_op_i || ie_wr_i || ret_i);
        req[0]    = abort_i;
        req[1]    = fault_i;
        req[2]    = irq_i && ie_q;
        req[3]    = violation;
        req[4]    = syscall_i;
    end

    // Cause code belonging to each request slot.
    function automatic cause_e slot_cause(input int idx);
        case (idx)
            0:       return CAUSE_ABORT;
            1:       return CAUSE_FAULT;
            2:       return CAUSE_IRQ;
            3:       return CAUSE_PRIV;
            default: return CAUSE_SYSCALL;
        endcase
    endfunction

    // Whether the slot's instruction did not complete (save current state).
    function automatic logic slot_use_cur(input int idx);
        return (idx != 2) && (idx != 4);
    endfunction

    // Pick the highest-priority request, or return/step if none.
    always_comb begin
        dec_o.act     = ACT_STEP;
        dec_o.cause   = CAUSE_SYSCALL;
        dec_o.use_cur = 1'b0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                dec_o.act     = ACT_ENTER;
                dec_o.cause   = slot_cause(i);
                dec_o.use_cur = slot_use_cur(i);
            end
        end
        if (dec_o.act == ACT_STEP && ret_i && priv_q) begin
            dec_o.act = ACT_RETURN;
        end
        dec_o.ie_we = (dec_o.act == ACT_STEP) && ie_wr_i && priv_q;
    end

    // Permit a generic privileged operation only in a plain kernel step.
    always_comb begin
        grant_o = priv_op_i && priv_q && (dec_o.act == ACT_STEP);
    end

endmodule

// File: rtl/trap_saved_ctx.sv
// Single-level saved context: return PC, user SP, previous privilege
// and the cause code. Written only on trap entry.
// Assumes nesting beyond one level is handled by software.
module trap_saved_ctx
    import trap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  cause_e            cause_i,
    input  logic [ADDR_W-1:0] save_pc_i,
    input  logic [ADDR_W-1:0] save_sp_i,
    input  logic              save_priv_i,
    output logic [ADDR_W-1:0] epc_o,
    output logic [ADDR_W-1:0] esp_o,
    output logic              epriv_o,
    output cause_e            cause_o
);

    // Capture the interrupted context on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            esp_o   <= '0;
            epriv_o <= 1'b0;
            cause_o <= CAUSE_SYSCALL;
        end else if (enter_i) begin
            epc_o   <= save_pc_i;
            esp_o   <= save_sp_i;
            epriv_o <= save_priv_i;
            cause_o <= cause_i;
        end
    end

endmodule

// File: rtl/trap_live_state.sv
// Architectural PC, SP, privilege bit and interrupt enable.
// Loads the step values, the entry values or the saved context,
// as the decision says. Assumes the decision is one-hot in effect.
module trap_live_state
    import trap_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR  = '0,
    parameter logic [ADDR_W-1:0] KSTACK_TOP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  decision_t         dec_i,
    input  logic [ADDR_W-1:0] step_pc_i,
    input  logic [ADDR_W-1:0] step_sp_i,
    input  logic [ADDR_W-1:0] vec_pc_i,
    input  logic [ADDR_W-1:0] entry_sp_i,
    input  logic [ADDR_W-1:0] ret_pc_i,
    input  logic [ADDR_W-1:0] ret_sp_i,
    input  logic              ret_priv_i,
    input  logic              ie_val_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              priv_o,
    output logic              ie_o
);

    // Update PC, SP and privilege for the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o   <= BOOT_ADDR;
            sp_o   <= KSTACK_TOP;
            priv_o <= 1'b1;
        end else begin
            case (dec_i.act)
                ACT_ENTER: begin
                    pc_o   <= vec_pc_i;
                    sp_o   <= entry_sp_i;
                    priv_o <= 1'b1;
                end
                ACT_RETURN: begin
                    pc_o   <= ret_pc_i;
                    sp_o   <= ret_sp_i;
                    priv_o <= ret_priv_i;
                end
                default: begin
                    pc_o <= step_pc_i;
                    sp_o <= step_sp_i;
                end
            endcase
        end
    end

    // Interrupt enable, written only by a permitted kernel write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_o <= 1'b0;
        end else if (dec_i.ie_we) begin
            ie_o <= ie_val_i;
        end
    end

endmodule

// File: rtl/trap_priv_unit.sv
// Top of the trap and privilege state unit. Joins the arbiter, the
// live state and the saved context, and forms the handler vector,
// the values to save and the stack to enter on.
// Assumes one instruction's strobes per cycle.
module trap_priv_unit
    import trap_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] SYSCALL_VEC = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] TRAP_VEC    = 32'h0000_0200,
    parameter logic [ADDR_W-1:0] KSTACK_TOP  = 32'h0000_F000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] step_pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              syscall_i,
    input  logic              irq_i,
    input  logic              fault_i,
    input  logic              abort_i,
    input  logic              priv_op_i,
    input  logic              ie_wr_i,
    input  logic              ie_val_i,
    input  logic              ret_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              priv_o,
    output logic              ie_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic              priv_grant_o
);

    decision_t         dec;
    logic [ADDR_W-1:0] save_pc;
    logic [ADDR_W-1:0] save_sp;
    logic [ADDR_W-1:0] entry_sp;
    logic [ADDR_W-1:0] vec_pc;
    logic [ADDR_W-1:0] epc;
    logic [ADDR_W-1:0] esp;
    logic              epriv;
    cause_e            cause_q;

    trap_arbiter u_arb (
        .priv_q    (priv_o),
        .ie_q      (ie_o),
        .syscall_i (syscall_i),
        .irq_i     (irq_i),
        .fault_i   (fault_i),
        .abort_i   (abort_i),
        .priv_op_i (priv_op_i),
        .ie_wr_i   (ie_wr_i),
        .ret_i     (ret_i),
        .dec_o     (dec),
        .grant_o   (priv_grant_o)
    );

    // Select saved values, entry stack and handler vector.
    always_comb begin
        save_pc  = dec.use_cur ? pc_o : step_pc_i;
        save_sp  = dec.use_cur ? sp_o : sp_i;
        entry_sp = priv_o ? save_sp : KSTACK_TOP;
        vec_pc   = (dec.cause == CAUSE_SYSCALL) ? SYSCALL_VEC : TRAP_VEC;
    end

    trap_live_state #(
        .ADDR_W     (ADDR_W),
        .BOOT_ADDR  (BOOT_ADDR),
        .KSTACK_TOP (KSTACK_TOP)
    ) u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (dec),
        .step_pc_i  (step_pc_i),
        .step_sp_i  (sp_i),
        .vec_pc_i   (vec_pc),
        .entry_sp_i (entry_sp),
        .ret_pc_i   (epc),
        .ret_sp_i   (esp),
        .ret_priv_i (epriv),
        .ie_val_i   (ie_val_i),
        .pc_o       (pc_o),
        .sp_o       (sp_o),
        .priv_o     (priv_o),
        .ie_o       (ie_o)
    );

    trap_saved_ctx #(
        .ADDR_W (ADDR_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (dec.act == ACT_ENTER),
        .cause_i     (dec.cause),
        .save_pc_i   (save_pc),
        .save_sp_i   (save_sp),
        .save_priv_i (priv_o),
        .epc_o       (epc),
        .esp_o       (esp),
        .epriv_o     (epriv),
        .cause_o     (cause_q)
    );

    // Expose the recorded cause.
    always_comb begin
        cause_o = cause_q;
    end

endmodule

// File: rtl/trap_priv_unit_chk.sv
// Property checker for trap_priv_unit, attached by bind.
// Observes ports only.
module trap_priv_unit_chk #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] SYSCALL_VEC = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] TRAP_VEC    = 32'h0000_0200,
    parameter logic [ADDR_W-1:0] KSTACK_TOP  = 32'h0000_F000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_i,
    input logic              fault_i,
    input logic              abort_i,
    input logic              ie_wr_i,
    input logic              ret_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic              priv_o,
    input logic              ie_o,
    input logic [2:0]        cause_o,
    input logic              priv_grant_o
);

    // R3
    rise_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_o) |-> (pc_o == SYSCALL_VEC || pc_o == TRAP_VEC));

    // R3
    rise_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_o) |-> (sp_o == KSTACK_TOP));

    // R5
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o <= 3'd4);

    // R11
    grant_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_grant_o |-> priv_o);

    // R7
    irq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && ie_o && !abort_i && !fault_i) |=> (cause_o == 3'd1 && pc_o == TRAP_VEC));

    // R8
    drop_on_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(priv_o) |-> $past(ret_i));

    // R10
    ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ie_wr_i && priv_o) |=> $stable(ie_o));

endmodule

bind trap_priv_unit trap_priv_unit_chk #(
    .ADDR_W      (ADDR_W),
    .SYSCALL_VEC (SYSCALL_VEC),
    .TRAP_VEC    (TRAP_VEC),
    .KSTACK_TOP  (KSTACK_TOP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_i        (irq_i),
    .fault_i      (fault_i),
    .abort_i      (abort_i),
    .ie_wr_i      (ie_wr_i),
    .ret_i        (ret_i),
    .pc_o         (pc_o),
    .sp_o         (sp_o),
    .priv_o       (priv_o),
    .ie_o         (ie_o),
    .cause_o      (cause_o),
    .priv_grant_o (priv_grant_o)
);

// File: tb/trap_priv_unit_tb_top.sv
`timescale 1ns/1ps
module trap_priv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] step_pc_i = '0;
    logic [31:0] sp_i = '0;
    logic        syscall_i = 0, irq_i = 0, fault_i = 0, abort_i = 0;
    logic        priv_op_i = 0, ie_wr_i = 0, ie_val_i = 0, ret_i = 0;
    logic [31:0] pc_o, sp_o;
    logic        priv_o, ie_o, priv_grant_o;
    logic [2:0]  cause_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // Behavioural reference state
    logic [31:0] m_pc, m_sp, e_pc, e_sp;
    logic        m_priv, m_ie, e_priv;
    int          m_cause;

    always #2.5 clk = ~clk;

    trap_priv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_pc_i(step_pc_i), .sp_i(sp_i),
        .syscall_i(syscall_i), .irq_i(irq_i), .fault_i(fault_i), .abort_i(abort_i),
        .priv_op_i(priv_op_i), .ie_wr_i(ie_wr_i), .ie_val_i(ie_val_i), .ret_i(ret_i),
        .pc_o(pc_o), .sp_o(sp_o), .priv_o(priv_o), .ie_o(ie_o),
        .cause_o(cause_o), .priv_grant_o(priv_grant_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    function automatic logic model_grant();
        logic viol, any;
        viol = !m_priv && (priv_op_i || ie_wr_i || ret_i);
        any  = abort_i || fault_i || (irq_i && m_ie) || viol || syscall_i || (ret_i && m_priv);
        return priv_op_i && m_priv && !any;
    endfunction

    task automatic model_enter(input int cause, input bit cur);
        logic [31:0] spc, ssp;
        spc = cur ? m_pc : step_pc_i;
        ssp = cur ? m_sp : sp_i;
        e_pc = spc; e_sp = ssp; e_priv = m_priv;
        m_sp = m_priv ? ssp : 32'h0000_F000;
        m_pc = (cause == 0) ? 32'h0000_0100 : 32'h0000_0200;
        m_priv = 1'b1;
        m_cause = cause;
    endtask

    task automatic model_update();
        if (abort_i) model_enter(3, 1);
        else if (fault_i) model_enter(2, 1);
        else if (irq_i && m_ie) model_enter(1, 0);
        else if (!m_priv && (priv_op_i || ie_wr_i || ret_i)) model_enter(4, 1);
        else if (syscall_i) model_enter(0, 0);
        else if (ret_i) begin
            m_pc = e_pc; m_sp = e_sp; m_priv = e_priv;
        end else begin
            if (ie_wr_i) m_ie = ie_val_i;
            m_pc = step_pc_i; m_sp = sp_i;
        end
    endtask

    task automatic compare_all();
        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "sp", sp_o, m_sp);
        chk(tag, "priv", {31'd0, priv_o}, {31'd0, m_priv});
        chk(tag, "ie", {31'd0, ie_o}, {31'd0, m_ie});
        chk(tag, "cause", {29'd0, cause_o}, m_cause);
    endtask

    // Drive one cycle of stimulus (at negedge) and compare every output.
    task automatic cyc(input logic sc, input logic iq, input logic fl, input logic ab,
                       input logic po, input logic iw, input logic iv, input logic rt,
                       input logic [31:0] spc, input logic [31:0] ssp);
        syscall_i = sc; irq_i = iq; fault_i = fl; abort_i = ab;
        priv_op_i = po; ie_wr_i = iw; ie_val_i = iv; ret_i = rt;
        step_pc_i = spc; sp_i = ssp;
        #1;
        chk(tag, "grant", {31'd0, priv_grant_o}, {31'd0, model_grant()});
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic [31:0] spc, input logic [31:0] ssp);
        cyc(0,0,0,0,0,0,0,0, spc, ssp);
    endtask

    initial begin
        m_pc = 32'h0; m_sp = 32'h0000_F000; m_priv = 1; m_ie = 0; m_cause = 0;
        e_pc = 0; e_sp = 0; e_priv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1";
        chk("R1", "pc", pc_o, 32'h0);
        chk("R1", "sp", sp_o, 32'h0000_F000);
        chk("R1", "priv", {31'd0, priv_o}, 32'd1);
        chk("R1", "ie", {31'd0, ie_o}, 32'd0);
        chk("R1", "cause", {29'd0, cause_o}, 32'd0);

        // R2 plain steps
        tag = "R2";
        idle(32'h4, 32'h0000_EFF0);
        idle(32'h8, 32'h0000_EFE0);
        chk("R2", "pc", pc_o, 32'h8);

        // R10 kernel write of enable, then R8 return to saved user context
        tag = "R10";
        cyc(0,0,0,0,0,1,1,0, 32'hC, 32'h0000_EFE0);
        chk("R10", "ie", {31'd0, ie_o}, 32'd1);
        tag = "R8";
        cyc(0,0,0,0,0,0,0,1, 32'h10, 32'h0000_EFE0);
        chk("R8", "priv", {31'd0, priv_o}, 32'd0);
        idle(32'h1000, 32'h0008_0000);
        idle(32'h1004, 32'h0008_0000);

        // R3 syscall from user
        tag = "R3";
        cyc(1,0,0,0,0,0,0,0, 32'h1008, 32'h0007_FFF0);
        chk("R3", "pc", pc_o, 32'h100);
        chk("R3", "sp", sp_o, 32'h0000_F000);
        idle(32'h104, 32'h0000_EF00);
        tag = "R8";
        cyc(0,0,0,0,0,0,0,1, 32'h108, 32'h0000_EF00);
        chk("R8", "pc", pc_o, 32'h1008);
        chk("R8", "sp", sp_o, 32'h0007_FFF0);

        // R4 interrupt with enable set
        tag = "R4";
        cyc(0,1,0,0,0,0,0,0, 32'h100C, 32'h0007_FFE0);
        chk("R4", "cause", {29'd0, cause_o}, 32'd1);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);

        // R7 interrupt and syscall together
        tag = "R7";
        cyc(1,1,0,0,0,0,0,0, 32'h1010, 32'h0007_FFE0);
        chk("R7", "cause", {29'd0, cause_o}, 32'd1);
        chk("R7", "pc", pc_o, 32'h200);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);

        // R6 user privileged operation, user enable write, user return
        tag = "R6";
        cyc(0,0,0,0,1,0,0,0, 32'h1014, 32'h0007_FFD0);
        chk("R6", "cause", {29'd0, cause_o}, 32'd4);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);
        cyc(0,0,0,0,0,1,0,0, 32'h1018, 32'h0007_FFD0);
        chk("R6", "ie kept", {31'd0, ie_o}, 32'd1);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);
        chk("R6", "retry pc", pc_o, 32'h1010);
        cyc(0,0,0,0,0,0,0,1, 32'h1014, 32'h0007_FFD0);
        chk("R6", "priv", {31'd0, priv_o}, 32'd1);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);

        // R5 fault saves current PC
        tag = "R5";
        cyc(0,0,1,0,0,0,0,0, 32'h2000, 32'h0007_0000);
        chk("R5", "cause", {29'd0, cause_o}, 32'd2);
        cyc(0,0,0,0,0,0,0,1, 32'h204, 32'h0000_EF00);
        chk("R5", "resume pc", pc_o, 32'h1010);
        // R7 abort over fault over irq
        tag = "R7";
        cyc(1,1,1,1,0,0,0,0, 32'h2000, 32'h0007_0000);
        chk("R7", "cause", {29'd0, cause_o}, 32'd3);

        // R9 trap inside kernel keeps stack
        tag = "R9";
        cyc(1,0,0,0,0,0,0,0, 32'h204, 32'h0000_E800);
        chk("R9", "sp", sp_o, 32'h0000_E800);

        // R11 grant in kernel, denied when a trap wins
        tag = "R11";
        cyc(0,0,0,0,1,0,0,0, 32'h104, 32'h0000_E800);
        cyc(1,0,0,0,1,0,0,0, 32'h108, 32'h0000_E800);

        // R4 enable cleared, interrupt ignored
        tag = "R4";
        cyc(0,0,0,0,0,1,0,0, 32'h104, 32'h0000_E800);
        cyc(0,1,0,0,0,0,0,0, 32'h108, 32'h0000_E700);
        chk("R4", "pc", pc_o, 32'h108);

        // R7 mixed random traffic
        tag = "R7";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 8, $urandom_range(0,9) == 0, r == 50, r == 51,
                (r > 60 && r < 66), (r > 70 && r < 74), $urandom_range(0,1) == 1,
                (r > 80 && r < 90), $urandom, $urandom);
        end
        finish_run();
    end

endmodule